// File: doc/BRIEF.md
# Accumulator Output Conditioner

This stage turns a wide two's complement accumulator result into a 16-bit two's complement output word. The conversion runs in three steps. First, an optional round-half-up at a bit position that software picks. Next, a 16-bit window is taken from the rounded value, and the window's lowest bit is also set by software. Last, the word is clamped between a programmable signed floor and ceiling.

Values that do not fit in the selected window saturate at the 16-bit signed bounds. The bounds are set in three registers written through a small write-only register port.

An output enable says whether a result is presented. When it is low, the output carries no valid word and reads zero. A result appears one clock after its input sample.

Top module: `acc_out_shaper`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid` is 0 and `dout` is 0. The control register resets to 0, the ceiling to 0x7FFF and the floor to 0x8000.
- R2: A sample presented with `in_valid` and `oe` both high at a rising edge gives `out_valid` high and its result on `dout` after exactly that one edge.
- R3: In any cycle where `in_valid` or `oe` is low, the next `out_valid` is 0 and the next `dout` is 0.
- R4: A write (`wr_en` high) uses `wr_addr` 0 for control, 1 for the signed ceiling and 2 for the signed floor. A sample in the same cycle as the write still uses the old settings, and later samples use the new ones.
- R5: The control word has these fields, with S = clog2(ACC_W): window lowest bit in bits [S-1:0], round position P in bits [2S-1:S], round enable in bit 2S and limit enable in bit 2S+1.
- R6: With rounding enabled and P > 0, 2^(P-1) is added to the sign-extended accumulator and bits below P are then cleared. With P = 0, or with rounding disabled, the value is unchanged.
- R7: The output is the rounded value arithmetically shifted right by the window lowest bit L, taken as a 16-bit word. This holds for any L from 0 to ACC_W-1, and L may lie below or above P.
- R8: If the shifted value exceeds 32767 the output is 0x7FFF, and if it is below -32768 the output is 0x8000.
- R9: With limiting enabled, a result above the ceiling becomes the ceiling and a result below the floor becomes the floor. Both comparisons are signed.
- R10: When the floor is above the ceiling and limiting is enabled, the ceiling wins, so every valid output equals the ceiling.
- R11: With limiting disabled, the ceiling and floor have no effect on the output.
- R12: A write to `wr_addr` 3 changes no setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | OUT_W | Register write value |
| acc_in | input | ACC_W | Accumulator sample, two's complement |
| in_valid | input | 1 | Sample present |
| oe | input | 1 | Output enable |
| dout | output | OUT_W | Conditioned output word |
| out_valid | output | 1 | Output word is driven |

## Verification
The bench builds the block with ACC_W = 24 and OUT_W = 16, which gives a five-bit window and round-position field. With only eight bits of headroom above the output word, both saturation directions are easy to reach with small stimulus. The narrower accumulator also brings cases within reach where the rounding position lies above the window's lowest bit. A seeded random sweep then changes all settings together, including inverted limits.

// File: rtl/oshp_pkg.sv
package oshp_pkg;

  typedef enum logic [1:0] {
    REG_CTRL  = 2'd0,
    REG_UPPER = 2'd1,
    REG_LOWER = 2'd2,
    REG_SPARE = 2'd3
  } oshp_reg_e;

  localparam int unsigned ADDR_W = 2;

endpackage

// File: rtl/oshp_cfg_regs.sv
module oshp_cfg_regs
  import oshp_pkg::*;
#(
  parameter int unsigned OUT_W = 16,
  parameter int unsigned SEL_W = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [OUT_W-1:0]        wr_data,
  output logic [SEL_W-1:0]        win_lsb,
  output logic [SEL_W-1:0]        round_pos,
  output logic                    round_en,
  output logic                    limit_en,
  output logic signed [OUT_W-1:0] upper_lim,
  output logic signed [OUT_W-1:0] lower_lim
);

  localparam int unsigned WIN_LO = 0;
  localparam int unsigned RND_LO = SEL_W;
  localparam int unsigned REN_B  = 2 * SEL_W;
  localparam int unsigned LEN_B  = 2 * SEL_W + 1;

  localparam logic [OUT_W-1:0] MAX_W = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] MIN_W = {1'b1, {(OUT_W-1){1'b0}}};

  oshp_reg_e sel;
  assign sel = oshp_reg_e'(wr_addr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_lsb   <= '0;
      round_pos <= '0;
      round_en  <= 1'b0;
      limit_en  <= 1'b0;
      upper_lim <= MAX_W;
      lower_lim <= MIN_W;
    end else if (wr_en) begin
      case (sel)
        REG_CTRL: begin
          win_lsb   <= wr_data[WIN_LO +: SEL_W];
          round_pos <= wr_data[RND_LO +: SEL_W];
          round_en  <= wr_data[REN_B];
          limit_en  <= wr_data[LEN_B];
        end
        REG_UPPER: upper_lim <= wr_data;
        REG_LOWER: lower_lim <= wr_data;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/oshp_round.sv
module oshp_round #(
  parameter int unsigned ACC_W = 40,
  parameter int unsigned SEL_W = 6,
  localparam int unsigned EXT_W = ACC_W + 1
) (
  input  logic [ACC_W-1:0] acc,
  input  logic             round_en,
  input  logic [SEL_W-1:0] round_pos,
  output logic [EXT_W-1:0] rounded,
  output logic             round_active
);

  function automatic logic [EXT_W-1:0] round_half_up(
    input logic [ACC_W-1:0] a,
    input logic [SEL_W-1:0] pos
  );
    logic [EXT_W-1:0] ext;
    logic [EXT_W-1:0] half;
    logic [EXT_W-1:0] keep;
    ext  = {a[ACC_W-1], a};
    half = (pos == '0) ? '0 : (EXT_W'(1) << (pos - SEL_W'(1)));
    keep = ~((EXT_W'(1) << pos) - EXT_W'(1));
    return (ext + half) & keep;
  endfunction

  assign round_active = round_en && (round_pos != '0);
  assign rounded = round_active ? round_half_up(acc, round_pos)
                                : {acc[ACC_W-1], acc};

endmodule

// File: rtl/oshp_window.sv
module oshp_window #(
  parameter int unsigned ACC_W = 40,
  parameter int unsigned OUT_W = 16,
  parameter int unsigned SEL_W = 6,
  localparam int unsigned EXT_W = ACC_W + 1
) (
  input  logic [EXT_W-1:0]        rounded,
  input  logic [SEL_W-1:0]        win_lsb,
  output logic signed [OUT_W-1:0] win_val,
  output logic                    sat_hi,
  output logic                    sat_lo
);

  localparam logic signed [EXT_W-1:0] HI_EXT =
    {{(EXT_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [EXT_W-1:0] LO_EXT =
    {{(EXT_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

  function automatic logic signed [EXT_W-1:0] take_window(
    input logic [EXT_W-1:0] v,
    input logic [SEL_W-1:0] lsb
  );
    return $signed(v) >>> lsb;
  endfunction

  logic signed [EXT_W-1:0] shifted;

  assign shifted = take_window(rounded, win_lsb);
  assign sat_hi  = shifted > HI_EXT;
  assign sat_lo  = shifted < LO_EXT;

  always_comb begin
    if (sat_hi)      win_val = HI_EXT[OUT_W-1:0];
    else if (sat_lo) win_val = LO_EXT[OUT_W-1:0];
    else             win_val = shifted[OUT_W-1:0];
  end

endmodule

// File: rtl/oshp_limit.sv
module oshp_limit #(
  parameter int unsigned OUT_W = 16
) (
  input  logic signed [OUT_W-1:0] val,
  input  logic                    limit_en,
  input  logic signed [OUT_W-1:0] upper_lim,
  input  logic signed [OUT_W-1:0] lower_lim,
  output logic signed [OUT_W-1:0] res,
  output logic                    clip_hi,
  output logic                    clip_lo
);

  function automatic logic signed [OUT_W-1:0] clamp_ceiling_wins(
    input logic signed [OUT_W-1:0] v,
    input logic signed [OUT_W-1:0] hi,
    input logic signed [OUT_W-1:0] lo
  );
    logic signed [OUT_W-1:0] t;
    t = (v < lo) ? lo : v;
    return (t > hi) ? hi : t;
  endfunction

  logic signed [OUT_W-1:0] floored;

  assign floored = (val < lower_lim) ? lower_lim : val;
  assign clip_lo = limit_en && (val < lower_lim);
  assign clip_hi = limit_en && (floored > upper_lim);
  assign res     = limit_en ? clamp_ceiling_wins(val, upper_lim, lower_lim) : val;

endmodule

// File: rtl/acc_out_shaper.sv
module acc_out_shaper
  import oshp_pkg::*;
#(
  parameter int unsigned ACC_W = 40,
  parameter int unsigned OUT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [OUT_W-1:0]  wr_data,
  input  logic [ACC_W-1:0]  acc_in,
  input  logic              in_valid,
  input  logic              oe,
  output logic [OUT_W-1:0]  dout,
  output logic              out_valid
);

  localparam int unsigned SEL_W = $clog2(ACC_W);
  localparam int unsigned EXT_W = ACC_W + 1;

  logic [SEL_W-1:0]        win_lsb;
  logic [SEL_W-1:0]        round_pos;
  logic                    round_en;
  logic                    limit_en;
  logic signed [OUT_W-1:0] upper_lim;
  logic signed [OUT_W-1:0] lower_lim;

  logic [EXT_W-1:0]        rounded;
  logic                    round_active;
  logic signed [OUT_W-1:0] win_val;
  logic                    sat_hi;
  logic                    sat_lo;
  logic signed [OUT_W-1:0] res;
  logic                    clip_hi;
  logic                    clip_lo;
  logic                    take;

  logic [OUT_W-1:0]        dout_q;
  logic                    valid_q;

  oshp_cfg_regs #(.OUT_W(OUT_W), .SEL_W(SEL_W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .win_lsb   (win_lsb),
    .round_pos (round_pos),
    .round_en  (round_en),
    .limit_en  (limit_en),
    .upper_lim (upper_lim),
    .lower_lim (lower_lim)
  );

  oshp_round #(.ACC_W(ACC_W), .SEL_W(SEL_W)) u_round (
    .acc          (acc_in),
    .round_en     (round_en),
    .round_pos    (round_pos),
    .rounded      (rounded),
    .round_active (round_active)
  );

  oshp_window #(.ACC_W(ACC_W), .OUT_W(OUT_W), .SEL_W(SEL_W)) u_window (
    .rounded (rounded),
    .win_lsb (win_lsb),
    .win_val (win_val),
    .sat_hi  (sat_hi),
    .sat_lo  (sat_lo)
  );

  oshp_limit #(.OUT_W(OUT_W)) u_limit (
    .val       (win_val),
    .limit_en  (limit_en),
    .upper_lim (upper_lim),
    .lower_lim (lower_lim),
    .res       (res),
    .clip_hi   (clip_hi),
    .clip_lo   (clip_lo)
  );

  assign take = in_valid && oe;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dout_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= take;
      dout_q  <= take ? res : '0;
    end
  end

  assign dout      = dout_q;
  assign out_valid = valid_q;

endmodule

// File: rtl/oshp_checker.sv
module oshp_checker #(
  parameter int unsigned OUT_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              oe,
  input logic              out_valid,
  input logic [OUT_W-1:0]  dout,
  input logic              sat_hi,
  input logic              sat_lo,
  input logic              clip_hi,
  input logic              clip_lo,
  input logic              round_active,
  input logic              limit_en,
  input logic [OUT_W-1:0]  upper_lim,
  input logic [OUT_W-1:0]  lower_lim
);

  localparam logic [OUT_W-1:0] MAXV = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] MINV = {1'b1, {(OUT_W-1){1'b0}}};

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && oe) |=> out_valid);

  assert_idle_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && oe) |=> (!out_valid && dout == '0));

  assert_sat_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && oe && sat_hi && !limit_en) |=> dout == MAXV);

  assert_sat_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && oe && sat_lo && !limit_en) |=> dout == MINV);

  assert_ceiling_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && oe && limit_en) |=> $signed(dout) <= $signed($past(upper_lim)));

  assert_floor_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && oe && limit_en && ($signed(lower_lim) <= $signed(upper_lim)))
      |=> $signed(dout) >= $signed($past(lower_lim)));

  assert_inverted_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && oe && limit_en && ($signed(lower_lim) > $signed(upper_lim)))
      |=> dout == $past(upper_lim));

  assert_no_clip_when_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !limit_en |-> !(clip_hi || clip_lo));

  always_comb begin
    if (rst_n) begin
      assert_sat_exclusive_R8: assert (!(sat_hi && sat_lo));
    end
  end

  logic unused_ok;
  assign unused_ok = round_active;

endmodule

bind acc_out_shaper oshp_checker #(.OUT_W(OUT_W)) u_chk (.*);

// File: tb/acc_out_shaper_bench.sv
module acc_out_shaper_bench;

  localparam int unsigned AW = 24;
  localparam int unsigned OW = 16;
  localparam int unsigned SW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_addr = '0;
  logic [OW-1:0] wr_data = '0;
  logic [AW-1:0] acc_in = '0;
  logic          in_valid = 1'b0;
  logic          oe = 1'b0;
  logic [OW-1:0] dout;
  logic          out_valid;

  always #4 clk = ~clk;

  acc_out_shaper #(.ACC_W(AW), .OUT_W(OW)) u_acc_out_shaper (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .acc_in    (acc_in),
    .in_valid  (in_valid),
    .oe        (oe),
    .dout      (dout),
    .out_valid (out_valid)
  );

  typedef struct {
    bit          v;
    logic [15:0] d;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;

  int m_wl = 0, m_rp = 0, m_up = 32767, m_lo = -32768;
  bit m_ren = 1'b0, m_len = 1'b0;

  function automatic logic [15:0] predict(input logic [AW-1:0] a);
    longint v;
    v = longint'($signed(a));
    if (m_ren && m_rp > 0) begin
      v = v + (longint'(1) <<< (m_rp - 1));
      v = (v >>> m_rp) <<< m_rp;
    end
    v = v >>> m_wl;
    if (v > 32767)  v = 32767;
    if (v < -32768) v = -32768;
    if (m_len) begin
      if (v < m_lo) v = m_lo;
      if (v > m_up) v = m_up;
    end
    return v[15:0];
  endfunction

  function automatic void model_write(input logic [1:0] ad, input logic [15:0] d);
    case (ad)
      2'd0: begin
        m_wl  = int'(d[SW-1:0]);
        m_rp  = int'(d[2*SW-1:SW]);
        m_ren = d[2*SW];
        m_len = d[2*SW+1];
      end
      2'd1: m_up = int'($signed(d));
      2'd2: m_lo = int'($signed(d));
      default: ;
    endcase
  endfunction

  function automatic logic [15:0] ctrl(input int wl, input int rp, input bit ren, input bit len);
    logic [15:0] c;
    c = '0;
    c[SW-1:0]    = wl[SW-1:0];
    c[2*SW-1:SW] = rp[SW-1:0];
    c[2*SW]      = ren;
    c[2*SW+1]    = len;
    return c;
  endfunction

  function automatic void push(input bit iv, input bit o, input logic [AW-1:0] a, input string tag);
    exp_t e;
    e.v   = iv && o;
    e.d   = (iv && o) ? predict(a) : 16'h0000;
    e.tag = tag;
    q.push_back(e);
  endfunction

  task automatic step(input logic [AW-1:0] a, input bit iv, input bit o, input string tag);
    @(negedge clk);
    wr_en = 1'b0; acc_in = a; in_valid = iv; oe = o;
    push(iv, o, a, tag);
  endtask

  task automatic sample(input logic [AW-1:0] a, input string tag);
    step(a, 1'b1, 1'b1, tag);
  endtask

  task automatic cfg_write(input logic [1:0] ad, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = ad; wr_data = d; in_valid = 1'b0; oe = 1'b0;
    push(1'b0, 1'b0, '0, "R4");
    model_write(ad, d);
  endtask

  task automatic write_with_sample(input logic [1:0] ad, input logic [15:0] d,
                                   input logic [AW-1:0] a, input string tag);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = ad; wr_data = d;
    acc_in = a; in_valid = 1'b1; oe = 1'b1;
    push(1'b1, 1'b1, a, tag);
    model_write(ad, d);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        e = q.pop_front();
        n_cmp++;
        if (out_valid !== e.v || dout !== e.d) begin
          n_bad++;
          $display("FAIL %s: got valid=%0b dout=%h, expected valid=%0b dout=%h",
                   e.tag, out_valid, dout, e.v, e.d);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (60000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got running, expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    #2;
    n_cmp++;
    if (out_valid !== 1'b0 || dout !== 16'h0000) begin
      n_bad++;
      $display("FAIL R1: got valid=%0b dout=%h, expected valid=0 dout=0000", out_valid, dout);
    end
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #2;
    n_cmp++;
    if (out_valid !== 1'b0 || dout !== 16'h0000) begin
      n_bad++;
      $display("FAIL R1: got valid=%0b dout=%h, expected valid=0 dout=0000", out_valid, dout);
    end

    // R1 defaults: window at bit 0, no rounding, no limits
    sample(24'h001234, "R1");
    sample(24'hFFF000, "R7");
    sample(24'h012345, "R8");
    sample(24'hFE0000, "R8");
    sample(24'h007FFF, "R8");
    sample(24'hFF8000, "R8");
    // R3 gating
    step(24'h000055, 1'b1, 1'b0, "R3");
    step(24'h000055, 1'b0, 1'b1, "R3");
    sample(24'h000055, "R2");

    // R7 window shift
    cfg_write(2'd0, ctrl(4, 0, 1'b0, 1'b0));
    sample(24'h012345, "R7");
    sample(24'hFEDCBB, "R7");
    cfg_write(2'd0, ctrl(23, 0, 1'b0, 1'b0));
    sample(24'h800000, "R7");
    sample(24'h7FFFFF, "R7");

    // R6 rounding
    cfg_write(2'd0, ctrl(4, 4, 1'b1, 1'b0));
    sample(24'h012348, "R6");
    sample(24'h012347, "R6");
    sample(24'hFFFFF8, "R6");
    sample(24'hFFFFF7, "R6");
    sample(24'h7FFFF8, "R8");
    cfg_write(2'd0, ctrl(4, 0, 1'b1, 1'b0));
    sample(24'h01234F, "R6");
    cfg_write(2'd0, ctrl(4, 8, 1'b1, 1'b0));
    sample(24'h012380, "R6");
    sample(24'h01237F, "R6");

    // R9 limits
    cfg_write(2'd1, 16'h0100);
    cfg_write(2'd2, 16'hFF00);
    cfg_write(2'd0, ctrl(0, 0, 1'b0, 1'b1));
    sample(24'h000500, "R9");
    sample(24'hFFFB00, "R9");
    sample(24'h000050, "R9");
    sample(24'h000100, "R9");
    sample(24'hFFFF00, "R9");

    // R11 limits ignored when disabled
    cfg_write(2'd0, ctrl(0, 0, 1'b0, 1'b0));
    sample(24'h000500, "R11");
    sample(24'hFFFB00, "R11");

    // R10 inverted limits
    cfg_write(2'd1, 16'hFFF0);
    cfg_write(2'd2, 16'h0010);
    cfg_write(2'd0, ctrl(0, 0, 1'b0, 1'b1));
    sample(24'h000000, "R10");
    sample(24'h004000, "R10");
    sample(24'hFF0000, "R10");

    // R12 spare address
    cfg_write(2'd1, 16'h0200);
    cfg_write(2'd2, 16'hFE00);
    cfg_write(2'd3, 16'hFFFF);
    sample(24'h000300, "R12");
    sample(24'hFFFC00, "R12");
    sample(24'h000123, "R12");

    // R4 write-cycle ordering
    write_with_sample(2'd0, ctrl(8, 0, 1'b0, 1'b0), 24'h001234, "R4");
    sample(24'h001234, "R4");
    write_with_sample(2'd1, 16'h0005, 24'h000700, "R4");
    sample(24'h000700, "R5");

    // Random sweep over all settings (R5, R6, R7, R8, R9, R10)
    for (int k = 0; k < 40; k++) begin
      cfg_write(2'd1, 16'($urandom));
      cfg_write(2'd2, 16'($urandom));
      cfg_write(2'd0, ctrl(int'($urandom_range(0, AW - 1)), int'($urandom_range(0, AW - 1)),
                           1'($urandom), 1'($urandom)));
      for (int j = 0; j < 12; j++) begin
        step(24'($urandom), 1'($urandom_range(0, 7) != 0), 1'($urandom_range(0, 7) != 0), "R5");
      end
    end

    @(negedge clk);
    wr_en = 1'b0; in_valid = 1'b0; oe = 1'b0;
    repeat (4) @(posedge clk);
    #3;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule